// File: doc/BRIEF.md
# Bit-Serial PHY Tuning-Register Writer

This block is a hardware sequencer that programs tuning values into the bit-addressed configuration space of up to three USB PHYs. A request names a target PHY, a start bit address, a data word of up to 32 bits and a bit length. The block drives one shared 16-bit control word to all PHYs. That word holds an address field, a single data bit and a separate strobe line for each PHY. The sequencer then walks the value one bit at a time, least significant bit first, into consecutive addresses. It issues one strobe pulse per bit.

Each bit goes through four phases in a fixed order: address setup, data setup, strobe high and strobe low. Every phase lasts a programmable number of clock cycles. Requests arrive over a valid/ready handshake. Only one request is in flight at any time. A completed write ends with a one-cycle done pulse. A request with an unusable PHY index or length ends with a one-cycle error pulse and is not carried out. A configuration input can limit the design to two PHYs.

A simple 256-bit configuration store per PHY is included as the write target. Each store samples the data bit on the rising edge of its own strobe. It can be read back one bit at a time through a read port, so the effect of the writes can be observed.

Top module: `phy_tune_writer`

## Requirements
- R1: The control word carries the bit address in bits 15:8 and the data bit in bit 7. The strobe for PHY n sits at bit 2n, so PHYs 0, 1 and 2 use bits 0, 2 and 4. Bits 1, 3, 5 and 6 are always zero.
- R2: An accepted request of length L produces exactly L strobe pulses. Pulse i (counting from 0) carries address (start+i) modulo 256 and data bit i of the data word, and it strobes only the requested PHY.
- R3: Each bit passes through four phases in order: address placed, data placed with the strobe low, strobe high, strobe low. Each phase lasts P cycles, where P is the phase_cycles input, or 1 when that input is 0. `req_ready` is therefore low for exactly 4*P*L cycles per accepted request.
- R4: At most one strobe bit is high at any time. The address and data fields do not change while a strobe is high.
- R5: `req_ready` is low from the cycle after acceptance until the done cycle. A request presented while the block is busy is neither accepted nor rejected.
- R6: `done` is high for exactly one cycle: the first cycle after the strobe-low phase of the last bit. `req_ready` is high in that same cycle.
- R7: A request is rejected when its PHY index is 3 or more, or 2 or more while `cfg_two_phy` is 1, or when its length is 0 or above 32. Rejection gives a one-cycle `err` in the cycle after the handshake, with `req_ready` still high, no strobe and no store change.
- R8: The store of PHY n writes the data bit into the addressed bit on the rising edge of strobe n. It ignores the strobes of other PHYs. It resets to all zeros and is read through `rd_phy`/`rd_addr`/`rd_bit`.
- R9: The control word is zero after reset. While the block is idle, all strobe bits are zero and the address and data fields keep the values of the last bit written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_two_phy | input | 1 | 1 limits valid PHY indices to 0 and 1 |
| phase_cycles | input | 4 | Cycles per bit phase (0 treated as 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_phy | input | 2 | Target PHY index |
| req_addr | input | 8 | Start bit address |
| req_data | input | 32 | Value to write, LSB first |
| req_len | input | 6 | Number of bits to write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| ctl_word | output | 16 | Shared control word to the PHYs |
| rd_phy | input | 2 | Store read PHY select |
| rd_addr | input | 8 | Store read bit address |
| rd_bit | output | 1 | Selected store bit |

## Verification
Every cycle, the assertions check that at most one strobe is high, that the strobes are zero whenever the block is idle, and that the address and data fields hold steady under a strobe and while idle. They also check that done and err are single-cycle pulses, that err only follows a presented request, and that a store changes only on its own strobe edge. Only the bench scenarios can show the rest. These are the exact address and data sequence of each write (including wrap past address 255), the phase length and the total busy time for different phase settings, the rejection of each kind of bad request, and the final store contents after the initialisation and squelch writes.

// File: rtl/phyw_pkg.sv
package phyw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SHI,
    ST_SLO
  } seq_state_e;

  localparam int CTL_DATA_POS = 7;
  localparam int CTL_LOW_W    = 8;
endpackage

// File: rtl/phyw_rst_sync.sv
module phyw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/phyw_req_check.sv
module phyw_req_check #(
  parameter int NUM_PHY = 3,
  parameter int DATA_W  = 32,
  parameter int PHY_W   = 2,
  parameter int LEN_W   = 6
) (
  input  logic             cfg_two_phy,
  input  logic [PHY_W-1:0] req_phy,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ok
);
  localparam int LIM_W = PHY_W + 1;

  logic [LIM_W-1:0] phy_limit;
  logic             phy_ok;
  logic             len_ok;

  always_comb begin
    phy_limit = cfg_two_phy ? LIM_W'(2) : LIM_W'(NUM_PHY);
    phy_ok    = ({1'b0, req_phy} < phy_limit);
    len_ok    = (req_len != '0) && (req_len <= LEN_W'(DATA_W));
    req_ok    = phy_ok && len_ok;
  end
endmodule

// File: rtl/phyw_seq.sv
module phyw_seq
  import phyw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 6,
  parameter int PHASE_W = 4,
  parameter int PHY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_ok,
  input  logic [PHY_W-1:0]   req_phy,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [PHASE_W-1:0] phase_cycles,
  output logic               req_ready,
  output logic               done,
  output logic               err,
  output logic               strobe_on,
  output logic [PHY_W-1:0]   phy_sel,
  output logic               load_addr,
  output logic [ADDR_W-1:0]  addr_val,
  output logic               load_data,
  output logic               data_val
);
  localparam int IDX_W = $clog2(DATA_W);

  seq_state_e        state_q, state_d;
  logic [PHASE_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0]   idx_q, idx_d;
  logic [PHY_W-1:0]   phy_q;
  logic [ADDR_W-1:0]  start_q;
  logic [DATA_W-1:0]  word_q;
  logic [LEN_W-1:0]   len_q;
  logic [PHASE_W-1:0] plen_q;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               accept;
  logic               cap_en;
  logic [PHASE_W-1:0] plen_in;
  logic               phase_end;
  logic               last_bit;

  assign plen_in   = (phase_cycles == '0) ? PHASE_W'(1) : phase_cycles;
  assign phase_end = (cnt_q == '0);
  assign last_bit  = (idx_q == (len_q - LEN_W'(1)));
  assign cap_en    = accept;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    accept    = 1'b0;
    load_addr = 1'b0;
    load_data = 1'b0;
    addr_val  = start_q + ADDR_W'(idx_q + LEN_W'(1));
    data_val  = word_q[idx_q[IDX_W-1:0]];
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_ok) begin
            accept    = 1'b1;
            state_d   = ST_ADDR;
            cnt_d     = plen_in - PHASE_W'(1);
            idx_d     = '0;
            load_addr = 1'b1;
            addr_val  = req_addr;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_ADDR: begin
        if (phase_end) begin
          state_d   = ST_DATA;
          cnt_d     = plen_q - PHASE_W'(1);
          load_data = 1'b1;
        end else begin
          cnt_d = cnt_q - PHASE_W'(1);
        end
      end
      ST_DATA: begin
        if (phase_end) begin
          state_d = ST_SHI;
          cnt_d   = plen_q - PHASE_W'(1);
        end else begin
          cnt_d = cnt_q - PHASE_W'(1);
        end
      end
      ST_SHI: begin
        if (phase_end) begin
          state_d = ST_SLO;
          cnt_d   = plen_q - PHASE_W'(1);
        end else begin
          cnt_d = cnt_q - PHASE_W'(1);
        end
      end
      ST_SLO: begin
        if (phase_end) begin
          if (last_bit) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d   = ST_ADDR;
            cnt_d     = plen_q - PHASE_W'(1);
            idx_d     = idx_q + LEN_W'(1);
            load_addr = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - PHASE_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q   <= '0;
      start_q <= '0;
      word_q  <= '0;
      len_q   <= '0;
      plen_q  <= '0;
    end else if (cap_en) begin
      phy_q   <= req_phy;
      start_q <= req_addr;
      word_q  <= req_data;
      len_q   <= req_len;
      plen_q  <= plen_in;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign strobe_on = (state_q == ST_SHI);
  assign phy_sel   = phy_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_only_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (!req_ready || done));

  assert_err_after_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(req_valid) && req_ready && !done));

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !req_valid) |=> !err);
endmodule

// File: rtl/phyw_ctl.sv
module phyw_ctl
  import phyw_pkg::*;
#(
  parameter int NUM_PHY = 3,
  parameter int ADDR_W  = 8,
  parameter int PHY_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          idle,
  input  logic                          load_addr,
  input  logic [ADDR_W-1:0]             addr_val,
  input  logic                          load_data,
  input  logic                          data_val,
  input  logic                          strobe_on,
  input  logic [PHY_W-1:0]              phy_sel,
  output logic [ADDR_W+CTL_LOW_W-1:0]   ctl_word,
  output logic [NUM_PHY-1:0]            strobe_vec
);
  logic [ADDR_W-1:0]    addr_q;
  logic                 dbit_q;
  logic [CTL_LOW_W-1:0] low_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_addr) begin
      addr_q <= addr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbit_q <= 1'b0;
    end else if (load_data) begin
      dbit_q <= data_val;
    end
  end

  for (genvar n = 0; n < NUM_PHY; n++) begin : g_stb
    assign strobe_vec[n] = strobe_on && (phy_sel == PHY_W'(n));
  end

  always_comb begin
    low_bits = '0;
    low_bits[CTL_DATA_POS] = dbit_q;
    for (int n = 0; n < NUM_PHY; n++) begin
      low_bits[2*n] = strobe_vec[n];
    end
  end

  assign ctl_word = {addr_q, low_bits};

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_vec));

  assert_fields_hold_under_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_vec != '0) |-> $stable({addr_q, dbit_q}));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle)) |-> $stable({addr_q, dbit_q}));
endmodule

// File: rtl/phyw_store.sv
module phyw_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q;
  logic [DEPTH-1:0] bits_d;
  logic             strobe_q;
  logic             wr_en;

  assign wr_en = strobe && !strobe_q;

  always_comb begin
    bits_d       = bits_q;
    bits_d[addr] = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (wr_en) begin
      bits_q <= bits_d;
    end
  end

  assign rd_bit = bits_q[rd_addr];

  assert_store_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && !strobe_q) |=> $stable(bits_q));
endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import phyw_pkg::*;
#(
  parameter int NUM_PHY = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PHASE_W = 4,
  localparam int PHY_W  = 2,
  localparam int LEN_W  = $clog2(DATA_W) + 1,
  localparam int CTL_W  = ADDR_W + CTL_LOW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_two_phy,
  input  logic [PHASE_W-1:0] phase_cycles,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PHY_W-1:0]   req_phy,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [LEN_W-1:0]   req_len,
  output logic               done,
  output logic               err,
  output logic [CTL_W-1:0]   ctl_word,
  input  logic [PHY_W-1:0]   rd_phy,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_bit
);
  logic               srst_n;
  logic               req_ok;
  logic               strobe_on;
  logic [PHY_W-1:0]   phy_sel;
  logic               load_addr;
  logic [ADDR_W-1:0]  addr_val;
  logic               load_data;
  logic               data_val;
  logic [NUM_PHY-1:0] strobe_vec;
  logic [NUM_PHY-1:0] rd_vec;

  phyw_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  phyw_req_check #(
    .NUM_PHY (NUM_PHY),
    .DATA_W  (DATA_W),
    .PHY_W   (PHY_W),
    .LEN_W   (LEN_W)
  ) u_chk (
    .cfg_two_phy (cfg_two_phy),
    .req_phy     (req_phy),
    .req_len     (req_len),
    .req_ok      (req_ok)
  );

  phyw_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W),
    .PHASE_W (PHASE_W),
    .PHY_W   (PHY_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (srst_n),
    .req_valid    (req_valid),
    .req_ok       (req_ok),
    .req_phy      (req_phy),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .req_len      (req_len),
    .phase_cycles (phase_cycles),
    .req_ready    (req_ready),
    .done         (done),
    .err          (err),
    .strobe_on    (strobe_on),
    .phy_sel      (phy_sel),
    .load_addr    (load_addr),
    .addr_val     (addr_val),
    .load_data    (load_data),
    .data_val     (data_val)
  );

  phyw_ctl #(
    .NUM_PHY (NUM_PHY),
    .ADDR_W  (ADDR_W),
    .PHY_W   (PHY_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (srst_n),
    .idle       (req_ready),
    .load_addr  (load_addr),
    .addr_val   (addr_val),
    .load_data  (load_data),
    .data_val   (data_val),
    .strobe_on  (strobe_on),
    .phy_sel    (phy_sel),
    .ctl_word   (ctl_word),
    .strobe_vec (strobe_vec)
  );

  for (genvar n = 0; n < NUM_PHY; n++) begin : g_store
    phyw_store #(
      .ADDR_W (ADDR_W)
    ) u_store (
      .clk     (clk),
      .rst_n   (srst_n),
      .strobe  (ctl_word[2*n]),
      .addr    (ctl_word[CTL_W-1:CTL_LOW_W]),
      .data    (ctl_word[CTL_DATA_POS]),
      .rd_addr (rd_addr),
      .rd_bit  (rd_vec[n])
    );
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int n = 0; n < NUM_PHY; n++) begin
      if (rd_phy == PHY_W'(n)) rd_bit = rd_vec[n];
    end
  end

  assert_idle_strobes_low_R9: assert property (@(posedge clk) disable iff (!srst_n)
    req_ready |-> (strobe_vec == '0));

  assert_spare_bits_zero_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl_word[1] == 1'b0) && (ctl_word[3] == 1'b0) && (ctl_word[5] == 1'b0)
      && (ctl_word[6] == 1'b0));
endmodule

// File: tb/tb_phy_tune_writer.sv
module tb_phy_tune_writer;
  logic        clk;
  logic        rst_n;
  logic        cfg_two_phy;
  logic [3:0]  phase_cycles;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_phy;
  logic [7:0]  req_addr;
  logic [31:0] req_data;
  logic [5:0]  req_len;
  logic        done;
  logic        err;
  logic [15:0] ctl_word;
  logic [1:0]  rd_phy;
  logic [7:0]  rd_addr;
  logic        rd_bit;

  int total = 0;
  int bad   = 0;
  int cur_p = 1;
  int cycles = 0;

  typedef struct packed {
    logic [1:0] phy;
    logic [7:0] addr;
    logic       dbit;
  } exp_t;

  exp_t        sb_q[$];
  logic [255:0] model [3];

  phy_tune_writer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_two_phy  (cfg_two_phy),
    .phase_cycles (phase_cycles),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_phy      (req_phy),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .req_len      (req_len),
    .done         (done),
    .err          (err),
    .ctl_word     (ctl_word),
    .rd_phy       (rd_phy),
    .rd_addr      (rd_addr),
    .rd_bit       (rd_bit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor: pops one expected bit per strobe rising edge
  logic [2:0]  prev_s = 3'b000;
  logic [15:0] prev_ctl = 16'h0;
  int          hi_cnt = 0;
  always @(negedge clk) begin
    logic [2:0] s;
    exp_t e;
    if (rst_n) begin
      s = {ctl_word[4], ctl_word[2], ctl_word[0]};
      if (s != 3'b000 && prev_s == 3'b000) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected strobe", s, 0);
        end else begin
          e = sb_q.pop_front();
          chk(s == (3'b001 << e.phy), "R2", "strobe line", s, 3'b001 << e.phy);
          chk(ctl_word[15:8] == e.addr, "R2", "address", ctl_word[15:8], e.addr);
          chk(ctl_word[7] == e.dbit, "R2", "data bit", ctl_word[7], e.dbit);
          chk({ctl_word[6:5], ctl_word[3], ctl_word[1]} == 4'b0, "R1", "spare bits",
              {ctl_word[6:5], ctl_word[3], ctl_word[1]}, 0);
          chk(prev_ctl[15:7] == ctl_word[15:7], "R4", "fields set before strobe",
              prev_ctl[15:7], ctl_word[15:7]);
        end
      end
      if (s != 3'b000) hi_cnt++;
      if (s == 3'b000 && prev_s != 3'b000) begin
        chk(hi_cnt == cur_p, "R3", "strobe high width", hi_cnt, cur_p);
        hi_cnt = 0;
      end
      prev_s   = s;
      prev_ctl = ctl_word;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic read_bit(input int p, input int a, output logic v);
    rd_phy  = 2'(p);
    rd_addr = 8'(a);
    #1;
    v = rd_bit;
  endtask

  task automatic check_range(input int p, input int a, input int len, input string req);
    logic v;
    for (int i = -1; i <= len; i++) begin
      int ad;
      ad = (a + i) & 255;
      read_bit(p, ad, v);
      chk(v == model[p][ad], req, "store bit", v, model[p][ad]);
    end
  endtask

  // driver: pushes expected bits, performs handshake, checks completion
  task automatic do_req(input int p, input int a, input logic [31:0] d, input int len,
                        input bit poke);
    bit ok;
    int busy;
    bit err_seen;
    int lim;
    lim = cfg_two_phy ? 2 : 3;
    ok  = (p < lim) && (len >= 1) && (len <= 32);
    cur_p = (phase_cycles == 0) ? 1 : int'(phase_cycles);
    if (ok) begin
      for (int i = 0; i < len; i++) begin
        exp_t e;
        e.phy  = 2'(p);
        e.addr = 8'((a + i) & 255);
        e.dbit = d[i];
        sb_q.push_back(e);
        if (p < 3) model[p][(a + i) & 255] = d[i];
      end
    end
    @(negedge clk);
    req_phy   = 2'(p);
    req_addr  = 8'(a);
    req_data  = d;
    req_len   = 6'(len);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (ok) begin
      if (poke) begin
        req_valid = 1'b1;
        req_len   = 6'd0;
      end
      busy = 0;
      err_seen = 0;
      while (!req_ready) begin
        busy++;
        if (err) err_seen = 1;
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(done == 1'b1, "R6", "done at return of ready", done, 1);
      chk(busy == 4 * cur_p * len, "R3", "busy cycles", busy, 4 * cur_p * len);
      if (poke) chk(!err_seen, "R5", "request while busy ignored", err_seen, 0);
      @(negedge clk);
      chk(done == 1'b0, "R6", "done single pulse", done, 0);
      chk(sb_q.size() == 0, "R2", "all bits strobed", sb_q.size(), 0);
      chk(ctl_word[15:8] == 8'((a + len - 1) & 255) && ctl_word[7] == d[len-1]
          && {ctl_word[4], ctl_word[2], ctl_word[0]} == 3'b000,
          "R9", "idle hold", ctl_word, {8'((a + len - 1) & 255), d[len-1], 7'b0});
    end else begin
      chk(err == 1'b1 && req_ready == 1'b1 && done == 1'b0, "R7", "reject pulse",
          {err, req_ready, done}, 3'b110);
      @(negedge clk);
      chk(err == 1'b0 && ctl_word[4] == 0 && ctl_word[2] == 0 && ctl_word[0] == 0,
          "R7", "reject quiet", {err, ctl_word[4], ctl_word[2], ctl_word[0]}, 0);
    end
    if (p < 3) check_range(p, a, (len > 32) ? 32 : len, ok ? "R8" : "R7");
  endtask

  initial begin
    logic v;
    for (int p = 0; p < 3; p++) model[p] = '0;
    rst_n = 1'b0;
    cfg_two_phy = 1'b0;
    phase_cycles = 4'd0;
    req_valid = 1'b0;
    req_phy = 0; req_addr = 0; req_data = 0; req_len = 0;
    rd_phy = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk(ctl_word == 16'h0, "R9", "control word after reset", ctl_word, 0);
    chk(req_ready && !done && !err, "R5", "idle outputs after reset",
        {req_ready, done, err}, 3'b100);
    read_bit(1, 8'h20, v);
    chk(v == 1'b0, "R8", "store reset", v, 0);

    // initialisation pattern, minimum phase length
    do_req(0, 8'h0C, 32'h1, 1, 0);
    do_req(0, 8'h20, 32'h14, 5, 0);
    do_req(0, 8'h2A, 32'h3, 2, 0);
    phase_cycles = 4'd2;
    do_req(1, 8'h20, 32'h14, 5, 0);
    do_req(1, 8'h2A, 32'h2, 2, 0);
    // squelch detection off then on, PHY 1 only
    do_req(1, 8'h3C, 32'h2, 2, 0);
    do_req(1, 8'h3C, 32'h0, 2, 1);
    // longer phases, full width, address wrap, PHY 2
    phase_cycles = 4'd3;
    do_req(2, 8'hF0, 32'hA5C3_0F96, 32, 0);
    phase_cycles = 4'd1;
    do_req(2, 8'h3C, 32'h2, 2, 1);

    // rejected requests
    do_req(3, 8'h10, 32'hFF, 4, 0);
    do_req(0, 8'h10, 32'hFF, 0, 0);
    do_req(0, 8'h10, 32'hFFFF_FFFF, 33, 0);
    cfg_two_phy = 1'b1;
    do_req(2, 8'h50, 32'hF, 4, 0);
    do_req(1, 8'h50, 32'hB, 4, 0);
    cfg_two_phy = 1'b0;
    do_req(2, 8'h50, 32'h6, 4, 0);

    // full store sweep: other PHYs untouched by foreign strobes
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 256; a++) begin
        read_bit(p, a, v);
        chk(v == model[p][a], "R8", "final store contents", v, model[p][a]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule